// File: doc/BRIEF.md
# Pipelined Floating-Point Multiplier

This block multiplies two floating-point words in a custom format. A word holds a sign bit in the top position, an 8-bit exponent biased by 128 below it, and a 56-bit stored fraction in the low bits. The stored fraction sits under an implied leading one of weight one half, so every nonzero mantissa lies in [0.5, 1). An operand whose exponent and fraction bits are all zero is the value zero, whatever its sign bit.

The datapath is cut into three register stages. The first stage slices the multiplier mantissa into fixed-width chunks and forms one partial product per chunk. The second stage folds the partial products into two partial sums. The third stage adds those sums, normalizes the result by at most one left shift, rounds at the first guard bit, fixes the exponent and saturates it on overflow or underflow. A new operand pair can enter on every cycle. Each result leaves exactly three clock edges later with a matching valid strobe.

Top module: `fpm_mul_pipe`

## Requirements
- R1: If either operand has all of bits 63:0 clear, the result word is all zeros, including a sign of 0, and both flags are clear.
- R2: out_valid is in_valid delayed by exactly three rising clock edges. A new pair is accepted on every cycle.
- R3: For a nonzero result, bit 64 of out_word is the XOR of the operand sign bits.
- R4: The result exponent, in bits 63:56, is the sum of the two raw exponent fields minus 128. It is then adjusted only as R5 and R7 state.
- R5: When the 114-bit mantissa product has its top bit clear, it is shifted left by one and the exponent is lowered by one. The kept mantissa always has its leading bit set.
- R6: Rounding adds the bit just below the 57 kept mantissa bits to the kept mantissa. Bits 55:0 of out_word are the kept mantissa without its leading bit.
- R7: If rounding carries out of the kept mantissa, the mantissa becomes exactly one half (fraction field 0) and the exponent is raised by one.
- R8: If the final exponent exceeds 255, out_ovf is set and the exponent field is 255.
- R9: If the final exponent is below 0, out_unf is set and the exponent field is 0.
- R10: While rst_n is low, out_valid, out_word, out_ovf and out_unf are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_a | input | 65 | First operand {sign, exponent, fraction} |
| in_b | input | 65 | Second operand {sign, exponent, fraction} |
| out_valid | output | 1 | Result present |
| out_word | output | 65 | Product {sign, exponent, fraction} |
| out_ovf | output | 1 | Exponent overflow, exponent saturated high |
| out_unf | output | 1 | Exponent underflow, exponent saturated low |

## Verification
Directed pairs cover the distinct arithmetic paths. A zero on either side with either sign tests R1. Two exact halves force the single left shift. A fraction of all ones except the lowest bit, times a fraction of one, makes the rounding carry wrap to exactly one half. Chosen exponent pairs land exactly on 255, on 0, just below 0 and far above 255, which separates correct saturation from an off-by-one. Random mid-range operands, with gaps in in_valid, then exercise both normalization branches and both guard-bit values against a bench model that normalizes by comparison and rounds by a half-add, and confirm that valid gaps flow through three stages unchanged.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int DEF_EXP_W  = 8;
  localparam int DEF_FRAC_W = 56;
  localparam int DEF_BIAS   = 128;
  localparam int DEF_CHUNK  = 16;

  // {overflow, underflow} for a final signed exponent against the field limit
  function automatic logic [1:0] exp_class(input int e, input int emax);
    return {e > emax, e < 0};
  endfunction
endpackage

// File: rtl/fpm_ppgen.sv
module fpm_ppgen #(
  parameter int EXP_W   = fpm_pkg::DEF_EXP_W,
  parameter int FRAC_W  = fpm_pkg::DEF_FRAC_W,
  parameter int BIAS    = fpm_pkg::DEF_BIAS,
  parameter int CHUNK_W = fpm_pkg::DEF_CHUNK,
  localparam int MW  = FRAC_W + 1,
  localparam int NPP = (MW + CHUNK_W - 1) / CHUNK_W,
  localparam int PPW = MW + CHUNK_W,
  localparam int EXW = EXP_W + 3,
  localparam int WW  = 1 + EXP_W + FRAC_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [WW-1:0]         in_a,
  input  logic [WW-1:0]         in_b,
  output logic                  s1_valid,
  output logic                  s1_zero,
  output logic                  s1_sign,
  output logic signed [EXW-1:0] s1_exp,
  output logic [NPP-1:0][PPW-1:0] s1_pp
);
  localparam int PADW = NPP * CHUNK_W;

  function automatic logic [EXW-1:0] exp_sum(input logic [EXP_W-1:0] ea,
                                             input logic [EXP_W-1:0] eb);
    return EXW'(ea) + EXW'(eb) - EXW'(BIAS);
  endfunction

  logic             zero_c;
  logic [MW-1:0]    ma;
  logic [PADW-1:0]  mb_pad;
  logic [NPP-1:0][PPW-1:0] pp_c;

  assign zero_c = ~|in_a[WW-2:0] | ~|in_b[WW-2:0];
  assign ma     = {1'b1, in_a[FRAC_W-1:0]};
  assign mb_pad = PADW'({1'b1, in_b[FRAC_W-1:0]});

  for (genvar i = 0; i < NPP; i++) begin : g_pp
    assign pp_c[i] = PPW'(ma) * PPW'(mb_pad[i*CHUNK_W +: CHUNK_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_zero  <= 1'b0;
      s1_sign  <= 1'b0;
      s1_exp   <= '0;
      s1_pp    <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_zero  <= zero_c;
      s1_sign  <= in_a[WW-1] ^ in_b[WW-1];
      s1_exp   <= exp_sum(in_a[WW-2 -: EXP_W], in_b[WW-2 -: EXP_W]);
      s1_pp    <= pp_c;
    end
  end

  // R2
  stage1_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);
  // R2
  stage1_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !s1_valid);
endmodule

// File: rtl/fpm_reduce.sv
module fpm_reduce #(
  parameter int EXP_W   = fpm_pkg::DEF_EXP_W,
  parameter int FRAC_W  = fpm_pkg::DEF_FRAC_W,
  parameter int CHUNK_W = fpm_pkg::DEF_CHUNK,
  localparam int MW   = FRAC_W + 1,
  localparam int NPP  = (MW + CHUNK_W - 1) / CHUNK_W,
  localparam int PPW  = MW + CHUNK_W,
  localparam int PW   = 2 * MW,
  localparam int EXW  = EXP_W + 3,
  localparam int HALF = NPP / 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s1_valid,
  input  logic                    s1_zero,
  input  logic                    s1_sign,
  input  logic signed [EXW-1:0]   s1_exp,
  input  logic [NPP-1:0][PPW-1:0] s1_pp,
  output logic                    s2_valid,
  output logic                    s2_zero,
  output logic                    s2_sign,
  output logic signed [EXW-1:0]   s2_exp,
  output logic [PW-1:0]           s2_lo,
  output logic [PW-1:0]           s2_hi
);
  logic [PW-1:0] lo_c, hi_c;

  always_comb begin
    lo_c = '0;
    hi_c = '0;
    for (int i = 0; i < NPP; i++) begin
      if (i < HALF) lo_c = lo_c + (PW'(s1_pp[i]) << (i * CHUNK_W));
      else          hi_c = hi_c + (PW'(s1_pp[i]) << (i * CHUNK_W));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_zero  <= 1'b0;
      s2_sign  <= 1'b0;
      s2_exp   <= '0;
      s2_lo    <= '0;
      s2_hi    <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_zero  <= s1_zero;
      s2_sign  <= s1_sign;
      s2_exp   <= s1_exp;
      s2_lo    <= lo_c;
      s2_hi    <= hi_c;
    end
  end

  // R5
  prod_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid && !s2_zero |-> (PW'(s2_lo + s2_hi) >= (PW'(1) << (PW - 2))));
endmodule

// File: rtl/fpm_normround.sv
module fpm_normround #(
  parameter int EXP_W  = fpm_pkg::DEF_EXP_W,
  parameter int FRAC_W = fpm_pkg::DEF_FRAC_W,
  localparam int MW   = FRAC_W + 1,
  localparam int PW   = 2 * MW,
  localparam int EXW  = EXP_W + 3,
  localparam int WW   = 1 + EXP_W + FRAC_W,
  localparam int EMAX = (1 << EXP_W) - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s2_valid,
  input  logic                  s2_zero,
  input  logic                  s2_sign,
  input  logic signed [EXW-1:0] s2_exp,
  input  logic [PW-1:0]         s2_lo,
  input  logic [PW-1:0]         s2_hi,
  output logic                  out_valid,
  output logic [WW-1:0]         out_word,
  output logic                  out_ovf,
  output logic                  out_unf
);
  function automatic logic [MW:0] add_guard(input logic [MW-1:0] kept,
                                            input logic guard);
    return {1'b0, kept} + (MW+1)'(guard);
  endfunction

  logic [PW-1:0]         prod;
  logic                  norm_shift;
  logic [MW-1:0]         kept;
  logic                  guard;
  logic [MW:0]           rsum;
  logic                  rnd_wrap;
  logic [MW-1:0]         mant_r;
  logic signed [EXW-1:0] exp_f;
  logic [1:0]            rng;
  logic [EXP_W-1:0]      exp_sat;

  assign prod       = s2_lo + s2_hi;
  assign norm_shift = ~prod[PW-1];
  assign kept       = norm_shift ? prod[PW-2 -: MW] : prod[PW-1 -: MW];
  assign guard      = norm_shift ? prod[PW-2-MW]    : prod[PW-1-MW];
  assign rsum       = add_guard(kept, guard);
  assign rnd_wrap   = rsum[MW];
  assign mant_r     = rnd_wrap ? rsum[MW:1] : rsum[MW-1:0];
  assign exp_f      = s2_exp - EXW'(norm_shift) + EXW'(rnd_wrap);
  assign rng        = fpm_pkg::exp_class(int'(exp_f), EMAX);
  assign exp_sat    = rng[1] ? {EXP_W{1'b1}} :
                      rng[0] ? {EXP_W{1'b0}} : exp_f[EXP_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_ovf   <= 1'b0;
      out_unf   <= 1'b0;
    end else begin
      out_valid <= s2_valid;
      if (s2_zero) begin
        out_word <= '0;
        out_ovf  <= 1'b0;
        out_unf  <= 1'b0;
      end else begin
        out_word <= {s2_sign, exp_sat, mant_r[FRAC_W-1:0]};
        out_ovf  <= rng[1];
        out_unf  <= rng[0];
      end
    end
  end

  // R5
  hidden_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid && !s2_zero |-> mant_r[MW-1]);
  // R7
  rnd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid && !s2_zero && rnd_wrap |-> (mant_r == (MW'(1) << (MW - 1))));
endmodule

// File: rtl/fpm_mul_pipe.sv
module fpm_mul_pipe #(
  parameter int EXP_W   = fpm_pkg::DEF_EXP_W,
  parameter int FRAC_W  = fpm_pkg::DEF_FRAC_W,
  parameter int BIAS    = fpm_pkg::DEF_BIAS,
  parameter int CHUNK_W = fpm_pkg::DEF_CHUNK,
  localparam int MW  = FRAC_W + 1,
  localparam int NPP = (MW + CHUNK_W - 1) / CHUNK_W,
  localparam int PPW = MW + CHUNK_W,
  localparam int PW  = 2 * MW,
  localparam int EXW = EXP_W + 3,
  localparam int WW  = 1 + EXP_W + FRAC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [WW-1:0] in_a,
  input  logic [WW-1:0] in_b,
  output logic          out_valid,
  output logic [WW-1:0] out_word,
  output logic          out_ovf,
  output logic          out_unf
);
  logic                    s1_valid, s1_zero, s1_sign;
  logic signed [EXW-1:0]   s1_exp;
  logic [NPP-1:0][PPW-1:0] s1_pp;
  logic                    s2_valid, s2_zero, s2_sign;
  logic signed [EXW-1:0]   s2_exp;
  logic [PW-1:0]           s2_lo, s2_hi;
  logic                    in_has_zero;

  assign in_has_zero = ~|in_a[WW-2:0] | ~|in_b[WW-2:0];

  fpm_ppgen #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS), .CHUNK_W(CHUNK_W)) u_st1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .s1_valid(s1_valid), .s1_zero(s1_zero), .s1_sign(s1_sign),
    .s1_exp(s1_exp), .s1_pp(s1_pp));

  fpm_reduce #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .CHUNK_W(CHUNK_W)) u_st2 (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_zero(s1_zero),
    .s1_sign(s1_sign), .s1_exp(s1_exp), .s1_pp(s1_pp),
    .s2_valid(s2_valid), .s2_zero(s2_zero), .s2_sign(s2_sign),
    .s2_exp(s2_exp), .s2_lo(s2_lo), .s2_hi(s2_hi));

  fpm_normround #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_st3 (
    .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_zero(s2_zero),
    .s2_sign(s2_sign), .s2_exp(s2_exp), .s2_lo(s2_lo), .s2_hi(s2_hi),
    .out_valid(out_valid), .out_word(out_word), .out_ovf(out_ovf), .out_unf(out_unf));

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);
  // R1
  zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_has_zero |-> ##3 (out_word == '0 && !out_ovf && !out_unf));
  // R8
  ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ovf |-> (&out_word[WW-2 -: EXP_W]) && !out_unf);
  // R9
  unf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unf |-> (out_word[WW-2 -: EXP_W] == '0));
endmodule

// File: tb/fpm_mul_pipe_tb.sv
`timescale 1ns/1ps
module fpm_mul_pipe_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [64:0] in_a = '0, in_b = '0;
  logic        out_valid, out_ovf, out_unf;
  logic [64:0] out_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        q_v[$];
  logic [66:0] q_e[$];
  string       q_t[$];

  always #2 clk = ~clk;

  fpm_mul_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_word(out_word), .out_ovf(out_ovf), .out_unf(out_unf));

  // returns {ovf, unf, word}; tag names the requirement the case stresses
  function automatic logic [66:0] ref_mul(input logic [64:0] a, input logic [64:0] b,
                                          output string tag);
    logic [113:0] ma, mb, p;
    logic [58:0]  r;
    logic [56:0]  mant;
    int e;
    bit sh, ov, un;
    if (a[63:0] == 0 || b[63:0] == 0) begin
      tag = "R1";
      return '0;
    end
    ma = {57'd0, 1'b1, a[55:0]};
    mb = {57'd0, 1'b1, b[55:0]};
    p  = ma * mb;
    e  = int'(a[63:56]) + int'(b[63:56]) - 128;
    sh = 1'b0;
    if (p < (114'd1 << 113)) begin
      p = p << 1; e = e - 1; sh = 1'b1;
    end
    r = ({1'b0, p[113:56]} + 59'd1) >> 1;
    if (r[57]) begin
      mant = r[57:1]; e = e + 1; tag = "R7";
    end else begin
      mant = r[56:0];
      tag = sh ? "R5" : (p[56] ? "R6" : "R4");
    end
    ov = e > 255;
    un = e < 0;
    if (ov) begin tag = "R8"; e = 255; end
    if (un) begin tag = "R9"; e = 0; end
    return {ov, un, a[64] ^ b[64], e[7:0], mant[55:0]};
  endfunction

  task automatic chk(input string tag, input logic [66:0] act, input logic [66:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // one cycle: compare the result due now, then drive the next pair
  task automatic step(input logic v, input logic [64:0] a, input logic [64:0] b);
    string t;
    logic [66:0] e;
    @(negedge clk);
    if (q_v.size() == 3) begin
      logic ev; logic [66:0] ee; string et;
      ev = q_v.pop_front(); ee = q_e.pop_front(); et = q_t.pop_front();
      chk("R2", {66'd0, out_valid}, {66'd0, ev});
      if (ev && out_valid) begin
        chk(et, {out_ovf, out_unf, out_word}, ee);
        if (ee[63:0] != 0) chk("R3", {66'd0, out_word[64]}, {66'd0, ee[64]});
      end
    end
    in_valid = v; in_a = a; in_b = b;
    e = ref_mul(a, b, t);
    q_v.push_back(v); q_e.push_back(e); q_t.push_back(t);
  endtask

  function automatic logic [64:0] mk(input logic s, input logic [7:0] ex, input logic [55:0] f);
    return {s, ex, f};
  endfunction

  function automatic logic [55:0] rfrac();
    return {$urandom, $urandom} & 56'hFF_FFFF_FFFF_FFFF;
  endfunction

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", {out_ovf, out_unf, out_word}, '0);
    chk("R10", {66'd0, out_valid}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    // directed corners
    step(1, mk(1, 8'd0, 56'd0), mk(0, 8'd140, 56'h123456789ABCDE));          // R1
    step(1, mk(1, 8'd135, 56'hFEDCBA98765432), mk(1, 8'd0, 56'd0));          // R1 sign 0
    step(1, mk(0, 8'd128, 56'd0), mk(1, 8'd128, 56'd0));                      // R5: 0.5*0.5
    step(1, mk(0, 8'd130, 56'hFF_FFFF_FFFF_FFFE), mk(0, 8'd131, 56'd1));      // R7 wrap
    step(1, mk(0, 8'd255, 56'h0F0F0F0F0F0F0F), mk(1, 8'd255, 56'h1234));     // R8
    step(1, mk(0, 8'd10, 56'd1), mk(0, 8'd20, 56'd1));                        // R9
    step(1, mk(0, 8'd200, 56'hFF_FFFF_FFFF_FFFF), mk(0, 8'd183, 56'hFF_FFFF_FFFF_FFFF)); // R4: exactly 255
    step(1, mk(1, 8'd64, 56'hFF_FFFF_FFFF_FFFF), mk(0, 8'd64, 56'hFF_FFFF_FFFF_FFFF));   // R4: exactly 0
    step(1, mk(0, 8'd64, 56'd0), mk(0, 8'd64, 56'd0));                        // R9: -1 after shift
    step(0, '0, '0);
    step(1, mk(1, 8'd129, 56'h80_0000_0000_0000), mk(1, 8'd127, 56'h80_0000_0000_0001)); // R6/R3
    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic v;
      logic [7:0] ea, eb;
      v  = ($urandom % 8) != 0;
      ea = ($urandom % 4 == 0) ? 8'($urandom) : 8'(100 + $urandom % 56);
      eb = ($urandom % 4 == 0) ? 8'($urandom) : 8'(100 + $urandom % 56);
      if ($urandom % 40 == 0) ea = 8'd0;
      step(v, mk(1'($urandom), ea, ($urandom % 40 == 1) ? 56'd0 : rfrac()),
              mk(1'($urandom), eb, rfrac()));
    end
    repeat (4) step(0, '0, '0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule